// File: doc/BRIEF.md
# Virtually Addressed Write-Through Line Cache

This block is a unified cache for instructions and data. It holds 256 lines of four 32-bit words. The lines are grouped into 4 sets of 64 ways each. The set is chosen by address bits [5:4], and the tag is address bits [31:6] of the untranslated (virtual) core address. Every cacheable read that misses fetches a whole line from memory, one word at a time, in rising word order. The word the core asked for is returned after the last word of the line has arrived. Writes are always sent on to memory. A write that hits either patches the cached bytes or drops the line, depending on the access's updateable attribute.

The core presents one request at a time while `req_ready` is high and then waits for a one-cycle `rsp_valid` pulse. Each access carries two attribute bits:
- The cacheable bit decides whether a read may be served from, or allocated into, the array.
- The updateable bit decides what a write hit does to the cached line.

The `cache_en` input is registered. The internal enable clears on reset, so the cache starts out disabled and follows `cache_en` one cycle later. While it is disabled, every access is a single-word memory transfer and the array is left alone.

Top module: `vwt_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, and `rsp_valid`, `mem_rd_req` and `mem_wr_req` are 0. No read can hit until a line has been filled after that reset.
- R2: While the cache is disabled, a read causes exactly one memory read of the word-aligned request address, and a write causes exactly one memory write. The array is neither looked up nor changed. Memory changes are visible on every access.
- R3: A cacheable read miss while enabled issues four memory reads, at the line base plus 0, 4, 8 and 12, in that order. The line is stored as valid, and the addressed word is returned once the fourth word has been accepted.
- R4: A cacheable read hit while enabled raises `rsp_valid` on the second rising edge after the request is accepted, and makes no memory read.
- R5: A read with the cacheable bit clear makes exactly one memory read and returns the memory word, even when the line is present. It never allocates: a later cacheable read of that line still misses.
- R6: Every write makes exactly one memory write with the word-aligned address, the write data and the byte enables (bit i enables bits 8i+7..8i). The response follows the memory acknowledge. A write makes no memory read.
- R7: A write hit with the updateable bit set replaces only the enabled bytes of the cached word. A following read of that word hits and returns the merged value.
- R8: A write hit with the updateable bit clear invalidates the line, so the next cacheable read of it misses.
- R9: A write miss allocates no line.
- R10: Each set has a 6-bit victim counter that starts at 0 after reset and advances by one on every fill into that set. A fill replaces the way named by that counter, so the 65th distinct line filled into a set evicts the first one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cache_en | input | 1 | Cache enable control (registered) |
| req_valid | input | 1 | Core request strobe |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Virtual byte address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for writes |
| req_cacheable | input | 1 | Access may use/allocate the array |
| req_updateable | input | 1 | Write hit patches the line (else drops it) |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid |
| mem_rd_req | output | 1 | Memory word read request, held until ack |
| mem_rd_addr | output | 32 | Word-aligned read address |
| mem_rd_ack | input | 1 | Read word accepted, data valid |
| mem_rd_data | input | 32 | Read data from memory |
| mem_wr_req | output | 1 | Memory write request, held until ack |
| mem_wr_addr | output | 32 | Word-aligned write address |
| mem_wr_data | output | 32 | Write data to memory |
| mem_wr_be | output | 4 | Write byte enables |
| mem_wr_ack | input | 1 | Write accepted |

## Verification
Reads are driven with the cache disabled, enabled and missing, enabled and hitting, and with the cacheable bit clear. Between these accesses the memory contents are changed behind the cache. A fresh value, a stale value or the number of memory reads then shows whether the access was served from the array or went to memory. Writes are tried as hits with and without the updateable bit and as misses. The read that follows each write tells a patched line, a dropped line and a line that was never allocated apart. Filling 65 distinct lines into one set, and then probing the first two, separates round-robin victim choice from any other choice.

// File: rtl/vwt_pkg.sv
package vwt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_FILL,
        ST_BYP,
        ST_WMEM
    } vwt_state_e;
endpackage

// File: rtl/vwt_line_store.sv
module vwt_line_store #(
    parameter int SETS   = 4,
    parameter int WAYS   = 64,
    parameter int TAG_W  = 26,
    parameter int LINE_W = 128,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [SET_W-1:0]             rd_set,
    input  logic [WAY_W-1:0]             rd_way,
    output logic [WAYS-1:0][TAG_W-1:0]   set_tags,
    output logic [WAYS-1:0]              set_valid,
    output logic [LINE_W-1:0]            rd_line,
    input  logic                         wr_en,
    input  logic [SET_W-1:0]             wr_set,
    input  logic [WAY_W-1:0]             wr_way,
    input  logic                         wr_valid,
    input  logic [TAG_W-1:0]             wr_tag,
    input  logic [LINE_W-1:0]            wr_line
);
    logic [SETS-1:0][WAYS-1:0] valid_q;
    logic [TAG_W-1:0]          tag_q  [SETS][WAYS];
    logic [LINE_W-1:0]         line_q [SETS][WAYS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_set][wr_way] <= wr_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set][wr_way]  <= wr_tag;
            line_q[wr_set][wr_way] <= wr_line;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign set_tags[w] = tag_q[rd_set][w];
    end
    assign set_valid = valid_q[rd_set];
    assign rd_line   = line_q[rd_set][rd_way];

    for (genvar s = 0; s < SETS; s++) begin : g_chk
        // R1: valid bits move only through the write port
        a_r1_valid_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> valid_q[s] == $past(valid_q[s]));
    end
endmodule

// File: rtl/vwt_tag_match.sv
module vwt_tag_match #(
    parameter int WAYS  = 64,
    parameter int TAG_W = 26,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
    input  logic [WAYS-1:0]            set_valid,
    input  logic [TAG_W-1:0]           look_tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = set_valid[w] && (set_tags[w] == look_tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_way = hit_way | WAY_W'(w);
        end
    end
    assign hit = |match;

    // R3: allocation only on a miss keeps a tag in at most one way
    a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/vwt_victim.sv
module vwt_victim #(
    parameter int SETS = 4,
    parameter int WAYS = 64,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] sel_set,
    output logic [WAY_W-1:0] vic_way,
    input  logic             adv,
    input  logic [SET_W-1:0] adv_set
);
    logic [SETS-1:0][WAY_W-1:0] ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (adv) ctr_d[adv_set] = ctr_q[adv_set] + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign vic_way = ctr_q[sel_set];

    for (genvar s = 0; s < SETS; s++) begin : g_chk
        // R10: counter steps by one per fill into its own set
        a_r10_step_on_fill: assert property (@(posedge clk) disable iff (!rst_n)
            (adv && adv_set == SET_W'(s)) |=> ctr_q[s] == $past(ctr_q[s]) + 1'b1);
        // R10: other sets' counters hold
        a_r10_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
            !(adv && adv_set == SET_W'(s)) |=> $stable(ctr_q[s]));
    end
endmodule

// File: rtl/vwt_cache.sv
module vwt_cache
    import vwt_pkg::*;
#(
    parameter int AW    = 32,
    parameter int SETS  = 4,
    parameter int WAYS  = 64,
    parameter int WORDS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cache_en,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [31:0]   req_wdata,
    input  logic [3:0]    req_be,
    input  logic          req_cacheable,
    input  logic          req_updateable,
    output logic          rsp_valid,
    output logic [31:0]   rsp_rdata,
    output logic          mem_rd_req,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rd_ack,
    input  logic [31:0]   mem_rd_data,
    output logic          mem_wr_req,
    output logic [AW-1:0] mem_wr_addr,
    output logic [31:0]   mem_wr_data,
    output logic [3:0]    mem_wr_be,
    input  logic          mem_wr_ack
);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int OFF_W  = WSEL_W + 2;
    localparam int SET_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TAG_W  = AW - OFF_W - SET_W;
    localparam int LINE_W = WORDS * 32;

    typedef struct packed {
        vwt_state_e       st;
        logic             en;
        logic             wr;
        logic [AW-1:0]    addr;
        logic [31:0]      wdata;
        logic [3:0]       be;
        logic             cach;
        logic             upd;
        logic [WSEL_W-1:0] cnt;
        logic [WAY_W-1:0] way;
        logic [LINE_W-1:0] fill_buf;
        logic             rsp;
        logic [31:0]      rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [SET_W-1:0]           look_set;
    logic [TAG_W-1:0]           look_tag;
    logic [WSEL_W-1:0]          word_sel;
    logic [WAYS-1:0][TAG_W-1:0] set_tags;
    logic [WAYS-1:0]            set_valid;
    logic [LINE_W-1:0]          rd_line;
    logic                       hit;
    logic [WAY_W-1:0]           hit_way;
    logic [WAY_W-1:0]           vic_way;
    logic                       ls_wr_en, ls_wr_valid, vic_adv;
    logic [WAY_W-1:0]           ls_wr_way;
    logic [LINE_W-1:0]          ls_wr_line;

    assign look_set = r_q.addr[OFF_W +: SET_W];
    assign look_tag = r_q.addr[AW-1 -: TAG_W];
    assign word_sel = r_q.addr[2 +: WSEL_W];

    vwt_line_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_set(look_set), .rd_way(hit_way),
        .set_tags(set_tags), .set_valid(set_valid), .rd_line(rd_line),
        .wr_en(ls_wr_en), .wr_set(look_set), .wr_way(ls_wr_way),
        .wr_valid(ls_wr_valid), .wr_tag(look_tag), .wr_line(ls_wr_line)
    );

    vwt_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .clk(clk), .rst_n(rst_n),
        .set_tags(set_tags), .set_valid(set_valid), .look_tag(look_tag),
        .hit(hit), .hit_way(hit_way)
    );

    vwt_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
        .clk(clk), .rst_n(rst_n),
        .sel_set(look_set), .vic_way(vic_way),
        .adv(vic_adv), .adv_set(look_set)
    );

    always_comb begin
        r_d         = r_q;
        r_d.rsp     = 1'b0;
        r_d.en      = cache_en;
        ls_wr_en    = 1'b0;
        ls_wr_valid = 1'b0;
        ls_wr_way   = hit_way;
        ls_wr_line  = rd_line;
        vic_adv     = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st    = ST_LOOK;
                    r_d.wr    = req_write;
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.be    = req_be;
                    r_d.cach  = req_cacheable;
                    r_d.upd   = req_updateable;
                end
            end
            ST_LOOK: begin
                if (r_q.wr) begin
                    if (r_q.en && hit) begin
                        ls_wr_en    = 1'b1;
                        ls_wr_valid = r_q.upd;
                        for (int b = 0; b < 4; b++) begin
                            if (r_q.be[b])
                                ls_wr_line[word_sel*32 + b*8 +: 8] = r_q.wdata[b*8 +: 8];
                        end
                    end
                    r_d.st = ST_WMEM;
                end else if (r_q.en && r_q.cach) begin
                    if (hit) begin
                        r_d.rsp   = 1'b1;
                        r_d.rdata = rd_line[word_sel*32 +: 32];
                        r_d.st    = ST_IDLE;
                    end else begin
                        r_d.cnt = '0;
                        r_d.way = vic_way;
                        r_d.st  = ST_FILL;
                    end
                end else begin
                    r_d.st = ST_BYP;
                end
            end
            ST_FILL: begin
                if (mem_rd_ack) begin
                    r_d.fill_buf[r_q.cnt*32 +: 32] = mem_rd_data;
                    if (r_q.cnt == WSEL_W'(WORDS-1)) begin
                        ls_wr_en    = 1'b1;
                        ls_wr_valid = 1'b1;
                        ls_wr_way   = r_q.way;
                        ls_wr_line  = r_d.fill_buf;
                        vic_adv     = 1'b1;
                        r_d.rsp     = 1'b1;
                        r_d.rdata   = r_d.fill_buf[word_sel*32 +: 32];
                        r_d.st      = ST_IDLE;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_BYP: begin
                if (mem_rd_ack) begin
                    r_d.rsp   = 1'b1;
                    r_d.rdata = mem_rd_data;
                    r_d.st    = ST_IDLE;
                end
            end
            ST_WMEM: begin
                if (mem_wr_ack) begin
                    r_d.rsp   = 1'b1;
                    r_d.rdata = '0;
                    r_d.st    = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready   = (r_q.st == ST_IDLE);
    assign rsp_valid   = r_q.rsp;
    assign rsp_rdata   = r_q.rdata;
    assign mem_rd_req  = (r_q.st == ST_FILL) || (r_q.st == ST_BYP);
    assign mem_rd_addr = (r_q.st == ST_FILL) ? {r_q.addr[AW-1:OFF_W], r_q.cnt, 2'b00}
                                             : {r_q.addr[AW-1:2], 2'b00};
    assign mem_wr_req  = (r_q.st == ST_WMEM);
    assign mem_wr_addr = {r_q.addr[AW-1:2], 2'b00};
    assign mem_wr_data = r_q.wdata;
    assign mem_wr_be   = r_q.be;

    // R4: a cacheable hit answers next cycle without touching memory
    a_r4_hit_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_LOOK && !r_q.wr && r_q.en && r_q.cach && hit)
            |=> rsp_valid && !mem_rd_req);
    // R3: fill words requested in ascending order
    a_r3_fill_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_FILL && mem_rd_ack && r_q.cnt != WSEL_W'(WORDS-1))
            |=> mem_rd_req && mem_rd_addr == $past(mem_rd_addr) + AW'(4));
    // R6: write request held steady until accepted
    a_r6_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_ack)
            |=> mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data) && $stable(mem_wr_be));
    // R6: never a read and a write to memory together
    a_r6_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req));
    // R5: a bypass read is a single transfer
    a_r5_bypass_single: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_BYP && mem_rd_ack) |=> !mem_rd_req && rsp_valid);
endmodule

// File: tb/sim_vwt_cache.sv
module sim_vwt_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cache_en = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        req_cacheable = 1'b0, req_updateable = 1'b0;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_rdata;
    logic        mem_rd_req, mem_wr_req;
    logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data;
    logic [3:0]  mem_wr_be;
    logic        mem_rd_ack = 1'b0, mem_wr_ack = 1'b0;
    logic [31:0] mem_rd_data = '0;

    int n_chk = 0, n_bad = 0;
    int rd_cnt = 0, wr_cnt = 0;
    logic [31:0] rd_log [16];
    logic [31:0] last_wa, last_wd;
    logic [3:0]  last_wbe;
    logic [31:0] ovr [logic [31:0]];

    always #5 clk = ~clk;

    vwt_cache u0 (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_cacheable(req_cacheable), .req_updateable(req_updateable),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_be(mem_wr_be), .mem_wr_ack(mem_wr_ack)
    );

    function automatic logic [31:0] mval(input logic [31:0] a);
        logic [31:0] k;
        k = {a[31:2], 2'b00};
        if (ovr.exists(k)) return ovr[k];
        return (k * 32'h0001_9E37) ^ 32'h5A5A_A5A5;
    endfunction

    function automatic logic [31:0] ad(input int tag, input int set, input int word);
        return {tag[25:0], set[1:0], word[1:0], 2'b00};
    endfunction

    // memory model: answers each request at the falling edge
    always @(negedge clk) begin
        if (mem_rd_req) begin
            mem_rd_ack  = 1'b1;
            mem_rd_data = mval(mem_rd_addr);
            rd_log[rd_cnt % 16] = mem_rd_addr;
            rd_cnt++;
        end else begin
            mem_rd_ack = 1'b0;
        end
        if (mem_wr_req) begin
            logic [31:0] v;
            v = mval(mem_wr_addr);
            for (int b = 0; b < 4; b++)
                if (mem_wr_be[b]) v[b*8 +: 8] = mem_wr_data[b*8 +: 8];
            ovr[{mem_wr_addr[31:2], 2'b00}] = v;
            last_wa = mem_wr_addr; last_wd = mem_wr_data; last_wbe = mem_wr_be;
            mem_wr_ack = 1'b1;
            wr_cnt++;
        end else begin
            mem_wr_ack = 1'b0;
        end
    end

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic xact(input logic wr, input logic [31:0] a, input logic [31:0] wd,
                        input logic [3:0] be, input logic c, input logic u,
                        output logic [31:0] rd, output int lat);
        int n;
        while (!req_ready) @(negedge clk);
        req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
        req_cacheable = c; req_updateable = u; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!rsp_valid && n < 60) begin
            @(negedge clk);
            n++;
        end
        if (n >= 60) begin
            n_chk++; n_bad++;
            $display("FAIL response timeout: actual=none expected=rsp_valid");
        end
        rd = rsp_rdata;
        lat = n;
        @(negedge clk);
    endtask

    task automatic rd_exp(input string rq, input logic [31:0] a, input logic c,
                          input logic [31:0] exp_d, input int exp_reads);
        logic [31:0] d; int l; int r0;
        r0 = rd_cnt;
        xact(1'b0, a, '0, '0, c, 1'b0, d, l);
        chk(rq, "read data", d, exp_d);
        chk(rq, "memory reads", rd_cnt - r0, exp_reads);
    endtask

    task automatic set_en(input logic e);
        cache_en = e;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1", "req_ready", req_ready, 1);
        chk("R1", "rsp_valid", rsp_valid, 0);
        chk("R1", "mem_rd_req", mem_rd_req, 0);
        chk("R1", "mem_wr_req", mem_wr_req, 0);
    endtask

    task automatic t_disabled;
        int w0;
        logic [31:0] d; int l;
        rd_exp("R2", ad(5, 1, 2), 1'b1, mval(ad(5, 1, 2)), 1);
        chk("R2", "single-word address", rd_log[(rd_cnt - 1) % 16], ad(5, 1, 2));
        ovr[ad(5, 1, 2)] = 32'hCAFE_0005;
        rd_exp("R2", ad(5, 1, 2), 1'b1, 32'hCAFE_0005, 1);
        w0 = wr_cnt;
        xact(1'b1, ad(5, 1, 3), 32'h0BAD_F00D, 4'hF, 1'b1, 1'b1, d, l);
        chk("R2", "disabled write transfers", wr_cnt - w0, 1);
    endtask

    task automatic t_fill_hit;
        logic [31:0] d; int l; int r0;
        set_en(1'b1);
        r0 = rd_cnt;
        rd_exp("R3", ad(7, 1, 2), 1'b1, mval(ad(7, 1, 2)), 4);
        for (int k = 0; k < 4; k++)
            chk("R3", "fill order", rd_log[(r0 + k) % 16], ad(7, 1, k));
        r0 = rd_cnt;
        xact(1'b0, ad(7, 1, 3), '0, '0, 1'b1, 1'b0, d, l);
        chk("R4", "hit data", d, mval(ad(7, 1, 3)));
        chk("R4", "hit latency", l, 1);
        chk("R4", "hit memory reads", rd_cnt - r0, 0);
    endtask

    task automatic t_uncached;
        logic [31:0] old;
        old = mval(ad(7, 1, 3));
        ovr[ad(7, 1, 3)] = 32'hDEAD_0001;
        rd_exp("R5", ad(7, 1, 3), 1'b0, 32'hDEAD_0001, 1);
        rd_exp("R5", ad(7, 1, 3), 1'b1, old, 0);
        ovr[ad(7, 1, 3)] = old;
        rd_exp("R5", ad(9, 2, 0), 1'b0, mval(ad(9, 2, 0)), 1);
        rd_exp("R5", ad(9, 2, 0), 1'b1, mval(ad(9, 2, 0)), 4);
    endtask

    task automatic t_write_hit;
        logic [31:0] d, old, mrg; int l; int w0, r0;
        old = mval(ad(7, 1, 1));
        mrg = {old[31:24], 8'h22, old[15:8], 8'h44};
        w0 = wr_cnt; r0 = rd_cnt;
        xact(1'b1, ad(7, 1, 1) | 32'h2, 32'h1122_3344, 4'b0101, 1'b1, 1'b1, d, l);
        chk("R6", "write transfers", wr_cnt - w0, 1);
        chk("R6", "write reads", rd_cnt - r0, 0);
        chk("R6", "write address", last_wa, ad(7, 1, 1));
        chk("R6", "write data", last_wd, 32'h1122_3344);
        chk("R6", "write enables", {28'd0, last_wbe}, 32'h5);
        ovr[ad(7, 1, 1)] = 32'h0000_0000;
        rd_exp("R7", ad(7, 1, 1), 1'b1, mrg, 0);
        ovr[ad(7, 1, 1)] = mrg;
    endtask

    task automatic t_write_inval;
        logic [31:0] d; int l;
        xact(1'b1, ad(7, 1, 0), 32'h7777_0000, 4'hF, 1'b1, 1'b0, d, l);
        ovr[ad(7, 1, 2)] = 32'hF00D_0002;
        rd_exp("R8", ad(7, 1, 2), 1'b1, 32'hF00D_0002, 4);
    endtask

    task automatic t_write_miss;
        logic [31:0] d; int l; int r0;
        r0 = rd_cnt;
        xact(1'b1, ad(11, 3, 0), 32'h1357_9BDF, 4'hF, 1'b1, 1'b1, d, l);
        chk("R9", "miss write reads", rd_cnt - r0, 0);
        rd_exp("R9", ad(11, 3, 0), 1'b1, 32'h1357_9BDF, 4);
    endtask

    task automatic t_disable_again;
        set_en(1'b0);
        ovr[ad(11, 3, 0)] = 32'h2468_ACE0;
        rd_exp("R2", ad(11, 3, 0), 1'b1, 32'h2468_ACE0, 1);
        set_en(1'b1);
    endtask

    task automatic t_replace;
        do_reset();
        @(negedge clk);
        rd_exp("R1", ad(11, 3, 0), 1'b1, mval(ad(11, 3, 0)), 4);
        for (int t = 100; t < 164; t++)
            rd_exp("R10", ad(t, 2, 0), 1'b1, mval(ad(t, 2, 0)), 4);
        rd_exp("R10", ad(100, 2, 1), 1'b1, mval(ad(100, 2, 1)), 0);
        rd_exp("R10", ad(164, 2, 0), 1'b1, mval(ad(164, 2, 0)), 4);
        rd_exp("R10", ad(101, 2, 0), 1'b1, mval(ad(101, 2, 0)), 0);
        rd_exp("R10", ad(100, 2, 0), 1'b1, mval(ad(100, 2, 0)), 4);
        rd_exp("R10", ad(101, 2, 0), 1'b1, mval(ad(101, 2, 0)), 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_fill_hit();
        t_uncached();
        t_write_hit();
        t_write_inval();
        t_write_miss();
        t_disable_again();
        t_replace();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule